// File: doc/BRIEF.md
# SPI Interrupt Status and Mask Unit

This block gathers the interrupt sources of a SPI controller whose transmit and receive FIFOs hold 32 entries each, and drives one interrupt line. Its inputs are the two FIFO occupancy counts, the two FIFO full flags and three single-cycle event pulses: transmit underflow, receive overflow and mode fail. The three events are caught in sticky bits that software clears by writing a 1 to them. The four other status bits are levels computed from the FIFO state on every cycle. Two of those levels compare an occupancy count against a programmable threshold.

The interrupt mask cannot be written directly. Software sets mask bits through an enable register and clears them through a disable register. The interrupt line is high whenever any status bit is set together with its mask bit. Register access is a single-cycle write strobe with combinational read data, and the bus decoder sits outside the block.

Register offsets are word indices on `regAddr`: 0 status, 1 mask enable, 2 mask disable, 3 mask, 4 transmit threshold, 5 receive threshold. Offsets 6 and 7 are unused.

Top module: `spi_irq_ctrl`

## Requirements
- R1: Status bit 5 equals `rxFull` and status bit 3 equals `txFull` in the same cycle, with no latching.
- R2: Status bit 4 is 1 exactly when `rxCount` is greater than or equal to the receive threshold, including a threshold of 0.
- R3: Status bit 2 is 1 exactly when `txCount` is strictly less than the transmit threshold. A threshold of 0 keeps it at 0.
- R4: A pulse on `txUnderflowEvt`, `modeFailEvt` or `rxOverflowEvt` sets status bit 6, 1 or 0 respectively from the next cycle onward. The bit then stays set.
- R5: A write to offset 0 clears each sticky bit (6, 1, 0) whose data bit is 1. It leaves the other sticky bits unchanged, and writing to level bits has no effect.
- R6: When an event pulse arrives in the same cycle as a write-1-to-clear of its bit, the bit stays set.
- R7: A write to offset 1 ORs data bits 6..0 into the mask. A write to offset 2 clears from the mask the bits that are 1 in data bits 6..0. Offset 3 reads the mask.
- R8: A write to offset 3 leaves the mask unchanged, and writes to offsets 6 and 7 change no state.
- R9: `irq` is the OR of the 7 bits of (mask AND status), and follows level changes in the same cycle.
- R10: After reset the mask is 0, the sticky bits are 0 and both thresholds are 1.
- R11: Reads of offsets 1, 2, 6 and 7 return 0.
- R12: Writes to offsets 4 and 5 load the transmit and receive thresholds from the low data bits. The thresholds read back zero-extended and take effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| txCount | input | 6 | Transmit FIFO occupancy (0..32) |
| rxCount | input | 6 | Receive FIFO occupancy (0..32) |
| txFull | input | 1 | Transmit FIFO full flag |
| rxFull | input | 1 | Receive FIFO full flag |
| txUnderflowEvt | input | 1 | Transmit underflow event pulse |
| rxOverflowEvt | input | 1 | Receive overflow event pulse |
| modeFailEvt | input | 1 | Mode fail event pulse |
| irq | output | 1 | Interrupt output |

## Verification
Two of the block's functions can hit the same sticky bit on the same clock edge: an event pulse setting the bit, and a write-1-to-clear of that bit. The bench forces this collision directly for each of the three sticky bits, and the random phase also produces it when it draws events and status writes independently. The expected result is that the bit reads 1 afterwards and the interrupt stays asserted when the bit is unmasked. A clear that arrives with no event must bring the bit back to 0.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  localparam int IRQ_W      = 7;
  localparam int REG_ADDR_W = 3;

  // status bit positions
  localparam int BIT_TX_UNDER  = 6;
  localparam int BIT_RX_FULL   = 5;
  localparam int BIT_RX_LEVEL  = 4;
  localparam int BIT_TX_FULL   = 3;
  localparam int BIT_TX_LEVEL  = 2;
  localparam int BIT_MODE_FAIL = 1;
  localparam int BIT_RX_OVER   = 0;

  localparam int NUM_STICKY = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    ADDR_STATUS  = 3'd0,
    ADDR_ENABLE  = 3'd1,
    ADDR_DISABLE = 3'd2,
    ADDR_MASK    = 3'd3,
    ADDR_TX_THR  = 3'd4,
    ADDR_RX_THR  = 3'd5
  } regAddrE;

  typedef enum logic [2:0] {
    SEL_STATUS,
    SEL_MASK,
    SEL_TX_THR,
    SEL_RX_THR,
    SEL_ZERO
  } rdSelE;

  typedef struct packed {
    logic clrStatus;
    logic setMask;
    logic clrMask;
    logic loadTxThr;
    logic loadRxThr;
  } ctrlStrobesT;

  // maps sticky slot index to its status bit position
  function automatic int stickyPos(input int idx);
    case (idx)
      0:       return BIT_RX_OVER;
      1:       return BIT_MODE_FAIL;
      default: return BIT_TX_UNDER;
    endcase
  endfunction

endpackage

// File: rtl/spi_irq_ctrl_decode.sv
module spi_irq_ctrl_decode
  import spi_irq_pkg::*;
(
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  output ctrlStrobesT           strobes,
  output rdSelE                 rdSel
);

  always_comb begin
    strobes = '0;
    if (regWrEn) begin
      case (regAddr)
        ADDR_STATUS:  strobes.clrStatus = 1'b1;
        ADDR_ENABLE:  strobes.setMask   = 1'b1;
        ADDR_DISABLE: strobes.clrMask   = 1'b1;
        ADDR_TX_THR:  strobes.loadTxThr = 1'b1;
        ADDR_RX_THR:  strobes.loadRxThr = 1'b1;
        default:      strobes = '0;
      endcase
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_STATUS: rdSel = SEL_STATUS;
      ADDR_MASK:   rdSel = SEL_MASK;
      ADDR_TX_THR: rdSel = SEL_TX_THR;
      ADDR_RX_THR: rdSel = SEL_RX_THR;
      default:     rdSel = SEL_ZERO;
    endcase
  end

endmodule

// File: rtl/spi_irq_ctrl_datapath.sv
module spi_irq_ctrl_datapath
  import spi_irq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 32,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  rdSelE             rdSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              txFull,
  input  logic              rxFull,
  input  logic              txUnderflowEvt,
  input  logic              rxOverflowEvt,
  input  logic              modeFailEvt,
  output logic [DATA_W-1:0] regRdData,
  output logic [IRQ_W-1:0]  statusBits,
  output logic [IRQ_W-1:0]  maskBits,
  output logic              irq
);

  logic [NUM_STICKY-1:0] evtVec;
  logic [NUM_STICKY-1:0] stickyQ;
  logic [IRQ_W-1:0]      maskQ;
  logic [CNT_W-1:0]      txThrQ;
  logic [CNT_W-1:0]      rxThrQ;
  logic                  rxLevel;
  logic                  txLevel;

  assign evtVec[0] = rxOverflowEvt;
  assign evtVec[1] = modeFailEvt;
  assign evtVec[2] = txUnderflowEvt;

  // sticky event bits: event beats a simultaneous clear
  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
    localparam int POS = stickyPos(i);
    logic clrHit;
    assign clrHit = strobes.clrStatus & regWrData[POS];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          stickyQ[i] <= 1'b0;
      else if (evtVec[i]) stickyQ[i] <= 1'b1;
      else if (clrHit)    stickyQ[i] <= 1'b0;
    end
  end

  // mask changes only through the set/clear strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 maskQ <= '0;
    else if (strobes.setMask)  maskQ <= maskQ | regWrData[IRQ_W-1:0];
    else if (strobes.clrMask)  maskQ <= maskQ & ~regWrData[IRQ_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txThrQ <= CNT_W'(1);
      rxThrQ <= CNT_W'(1);
    end else begin
      if (strobes.loadTxThr) txThrQ <= regWrData[CNT_W-1:0];
      if (strobes.loadRxThr) rxThrQ <= regWrData[CNT_W-1:0];
    end
  end

  assign rxLevel = (rxCount >= rxThrQ);
  assign txLevel = (txCount <  txThrQ);

  always_comb begin
    statusBits                = '0;
    statusBits[BIT_TX_UNDER]  = stickyQ[2];
    statusBits[BIT_RX_FULL]   = rxFull;
    statusBits[BIT_RX_LEVEL]  = rxLevel;
    statusBits[BIT_TX_FULL]   = txFull;
    statusBits[BIT_TX_LEVEL]  = txLevel;
    statusBits[BIT_MODE_FAIL] = stickyQ[1];
    statusBits[BIT_RX_OVER]   = stickyQ[0];
  end

  assign maskBits = maskQ;
  assign irq      = |(maskQ & statusBits);

  always_comb begin
    case (rdSel)
      SEL_STATUS: regRdData = DATA_W'(statusBits);
      SEL_MASK:   regRdData = DATA_W'(maskQ);
      SEL_TX_THR: regRdData = DATA_W'(txThrQ);
      SEL_RX_THR: regRdData = DATA_W'(rxThrQ);
      default:    regRdData = '0;
    endcase
  end

endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 32,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [CNT_W-1:0]      txCount,
  input  logic [CNT_W-1:0]      rxCount,
  input  logic                  txFull,
  input  logic                  rxFull,
  input  logic                  txUnderflowEvt,
  input  logic                  rxOverflowEvt,
  input  logic                  modeFailEvt,
  output logic                  irq
);

  ctrlStrobesT      strobes;
  rdSelE            rdSel;
  logic [IRQ_W-1:0] statusBits;
  logic [IRQ_W-1:0] maskBits;

  spi_irq_ctrl_decode u_decode (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  spi_irq_ctrl_datapath #(
    .DATA_W     (DATA_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) u_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .rdSel          (rdSel),
    .regWrData      (regWrData),
    .txCount        (txCount),
    .rxCount        (rxCount),
    .txFull         (txFull),
    .rxFull         (rxFull),
    .txUnderflowEvt (txUnderflowEvt),
    .rxOverflowEvt  (rxOverflowEvt),
    .modeFailEvt    (modeFailEvt),
    .regRdData      (regRdData),
    .statusBits     (statusBits),
    .maskBits       (maskBits),
    .irq            (irq)
  );

endmodule

// File: rtl/spi_irq_ctrl_checker.sv
module spi_irq_ctrl_checker
  import spi_irq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWrEn,
  input logic [REG_ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0]     regWrData,
  input logic [DATA_W-1:0]     regRdData,
  input logic                  txUnderflowEvt,
  input logic                  rxOverflowEvt,
  input logic                  modeFailEvt,
  input logic [IRQ_W-1:0]      statusBits,
  input logic [IRQ_W-1:0]      maskBits,
  input logic                  irq
);

  logic wrStatus;
  assign wrStatus = regWrEn && (regAddr == ADDR_STATUS);

  AST_UNDER_SETS: assert property (@(posedge clk) disable iff (!rstN)
    txUnderflowEvt |=> statusBits[BIT_TX_UNDER]); // R6

  AST_OVER_SETS: assert property (@(posedge clk) disable iff (!rstN)
    rxOverflowEvt |=> statusBits[BIT_RX_OVER]); // R4

  AST_FAIL_SETS: assert property (@(posedge clk) disable iff (!rstN)
    modeFailEvt |=> statusBits[BIT_MODE_FAIL]); // R4

  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (statusBits[BIT_MODE_FAIL] && !(wrStatus && regWrData[BIT_MODE_FAIL]))
      |=> statusBits[BIT_MODE_FAIL]); // R5

  AST_MASK_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_ENABLE)
      |=> ((maskBits & $past(regWrData[IRQ_W-1:0])) == $past(regWrData[IRQ_W-1:0]))); // R7

  AST_MASK_DISABLE: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_DISABLE)
      |=> ((maskBits & $past(regWrData[IRQ_W-1:0])) == '0)); // R7

  AST_MASK_NO_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_MASK) |=> $stable(maskBits)); // R8

  AST_ENDIS_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_ENABLE || regAddr == ADDR_DISABLE) |-> (regRdData == '0)); // R11

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (maskBits == '0) |-> !irq); // R9

endmodule

bind spi_irq_ctrl spi_irq_ctrl_checker #(.DATA_W(DATA_W)) u_checker (.*);

// File: tb/spi_irq_ctrl_bench.sv
`timescale 1ns/1ps
module spi_irq_ctrl_bench;

  localparam int DATA_W = 32;
  localparam int CNT_W  = 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [2:0]        regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic [CNT_W-1:0]  txCount = '0;
  logic [CNT_W-1:0]  rxCount = '0;
  logic              txFull = 1'b0;
  logic              rxFull = 1'b0;
  logic              txUnderflowEvt = 1'b0;
  logic              rxOverflowEvt = 1'b0;
  logic              modeFailEvt = 1'b0;
  logic              irq;

  int totalChecks = 0;
  int failChecks  = 0;

  // reference state
  logic [2:0]       mSticky;   // {under, fail, over}
  logic [6:0]       mMask;
  logic [CNT_W-1:0] mTxThr;
  logic [CNT_W-1:0] mRxThr;

  always #5 clk = ~clk;

  spi_irq_ctrl u_spi_irq_ctrl (.*);

  function automatic logic [6:0] expStatus();
    return {mSticky[2], rxFull, (rxCount >= mRxThr), txFull,
            (txCount < mTxThr), mSticky[1], mSticky[0]};
  endfunction

  function automatic logic [31:0] expRead(input logic [2:0] a);
    case (a)
      3'd0:    return 32'(expStatus());
      3'd3:    return 32'(mMask);
      3'd4:    return 32'(mTxThr);
      3'd5:    return 32'(mRxThr);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    totalChecks++;
    if (act !== exp) begin
      failChecks++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // read offset a and compare to the model, plus the interrupt line
  task automatic readCheck(input logic [2:0] a, input string req);
    regAddr = a;
    #1;
    check(regRdData, expRead(a), req);
    check(32'(irq), 32'(|(mMask & expStatus())), "R9 irq");
  endtask

  // apply one clock edge, advancing the model with the current inputs
  task automatic tick();
    logic [2:0]       nSticky;
    logic [6:0]       nMask;
    logic [CNT_W-1:0] nTx;
    logic [CNT_W-1:0] nRx;
    logic [2:0]       evt;
    logic [2:0]       clr;
    nSticky = mSticky; nMask = mMask; nTx = mTxThr; nRx = mRxThr;
    evt = {txUnderflowEvt, modeFailEvt, rxOverflowEvt};
    clr = '0;
    if (regWrEn) begin
      case (regAddr)
        3'd0: clr = {regWrData[6], regWrData[1], regWrData[0]};
        3'd1: nMask = mMask | regWrData[6:0];
        3'd2: nMask = mMask & ~regWrData[6:0];
        3'd4: nTx = regWrData[CNT_W-1:0];
        3'd5: nRx = regWrData[CNT_W-1:0];
        default: ;
      endcase
    end
    nSticky = (mSticky & ~clr) | evt;
    @(posedge clk);
    mSticky = nSticky; mMask = nMask; mTxThr = nTx; mRxThr = nRx;
    @(negedge clk);
    regWrEn = 1'b0;
    txUnderflowEvt = 1'b0; rxOverflowEvt = 1'b0; modeFailEvt = 1'b0;
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
  endtask

  initial begin
    #2_000_000;
    failChecks++;
    totalChecks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    mSticky = '0; mMask = '0; mTxThr = 1; mRxThr = 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset values
    readCheck(3'd3, "R10 mask reset");
    readCheck(3'd4, "R10 tx threshold reset");
    readCheck(3'd5, "R10 rx threshold reset");
    readCheck(3'd0, "R10 status reset");

    // R1 full flags pass straight through
    rxFull = 1; txFull = 0; readCheck(3'd0, "R1 rx full");
    rxFull = 0; txFull = 1; readCheck(3'd0, "R1 tx full");
    txFull = 0;

    // R12 thresholds, R2/R3 boundaries
    writeReg(3'd5, 32'hFFFF_FF08);
    readCheck(3'd5, "R12 rx threshold load");
    rxCount = 7; readCheck(3'd0, "R2 rx below threshold");
    rxCount = 8; readCheck(3'd0, "R2 rx at threshold");
    writeReg(3'd4, 32'd4);
    readCheck(3'd4, "R12 tx threshold load");
    txCount = 4; readCheck(3'd0, "R3 tx at threshold");
    txCount = 3; readCheck(3'd0, "R3 tx below threshold");
    writeReg(3'd5, 32'd0); rxCount = 0;
    readCheck(3'd0, "R2 rx threshold zero");
    writeReg(3'd4, 32'd0); txCount = 0;
    readCheck(3'd0, "R3 tx threshold zero");

    // R7 enable/disable, R11 read zero, R8 direct write ignored
    writeReg(3'd1, 32'h0000_0043);
    readCheck(3'd3, "R7 enable sets mask");
    readCheck(3'd1, "R11 enable reads zero");
    readCheck(3'd2, "R11 disable reads zero");
    writeReg(3'd3, 32'h0000_0000);
    readCheck(3'd3, "R8 direct mask write ignored");
    writeReg(3'd6, 32'hFFFF_FFFF);
    writeReg(3'd7, 32'hFFFF_FFFF);
    readCheck(3'd3, "R8 unused offsets keep mask");
    readCheck(3'd4, "R8 unused offsets keep threshold");
    readCheck(3'd6, "R11 unused offset reads zero");
    writeReg(3'd2, 32'h0000_0001);
    readCheck(3'd3, "R7 disable clears mask bit");

    // R4 sticky set and hold
    txUnderflowEvt = 1; tick();
    readCheck(3'd0, "R4 underflow sets bit 6");
    tick(); tick();
    readCheck(3'd0, "R4 underflow holds");
    rxOverflowEvt = 1; modeFailEvt = 1; tick();
    readCheck(3'd0, "R4 overflow and mode fail set");

    // R5 selective clear, level bits unaffected
    rxFull = 1;
    writeReg(3'd0, 32'h0000_0022);
    readCheck(3'd0, "R5 clear mode fail only");
    rxFull = 0;

    // R6 event beats clear, for each sticky bit
    txUnderflowEvt = 1; writeReg(3'd0, 32'h0000_0040);
    readCheck(3'd0, "R6 underflow event wins");
    modeFailEvt = 1; writeReg(3'd0, 32'h0000_0002);
    readCheck(3'd0, "R6 mode fail event wins");
    rxOverflowEvt = 1; writeReg(3'd0, 32'h0000_0001);
    readCheck(3'd0, "R6 overflow event wins");
    writeReg(3'd0, 32'h0000_0043);
    readCheck(3'd0, "R5 clear all sticky");

    // random phase
    for (int n = 0; n < 400; n++) begin
      txCount = CNT_W'($urandom_range(0, 32));
      rxCount = CNT_W'($urandom_range(0, 32));
      txFull  = ($urandom_range(0, 3) == 0);
      rxFull  = ($urandom_range(0, 3) == 0);
      readCheck(3'($urandom_range(0, 7)), "R9 random read");
      txUnderflowEvt = ($urandom_range(0, 7) == 0);
      rxOverflowEvt  = ($urandom_range(0, 7) == 0);
      modeFailEvt    = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 2) == 0) begin
        regWrEn   = 1'b1;
        regAddr   = 3'($urandom_range(0, 7));
        regWrData = $urandom();
        if (regAddr == 3'd4 || regAddr == 3'd5)
          regWrData = 32'($urandom_range(0, 33));
      end
      tick();
    end

    $display("%0d/%0d checks passed", totalChecks - failChecks, totalChecks);
    $finish;
  end

endmodule